// File: doc/BRIEF.md
# ATAPI Packet Command Sequencer

This block is the device-side control of an optical drive sitting on a parallel ATA task-file interface. It decodes host reads and writes of the task-file registers. It produces the status, interrupt-reason and byte-count values the host polls. It also runs the packet protocol. The host writes the packet command code, then streams a 12-byte command packet through the 16-bit data port. The block then either executes the command itself or hands it to a backend.

Two commands are served internally. TEST UNIT READY fails while a media-change unit attention is pending. REQUEST SENSE returns an 18-byte sense block and clears the check condition. The block holds a single sense record, and any new error overwrites it. A media-change pulse from outside latches the unit attention and raises the interrupt line. Every other opcode is presented on a request/done handshake, and the backend may report a failure together with its own sense key and additional code.

Top module: `atapi_pkt_seq`

## Requirements
- R1: After reset, intrq is low. Once the device is selected, status reads 0x50, interrupt reason (sector count, address 2) reads 0x00 and the error register (address 1) reads 0x00.
- R2: Writing 0xA0 to the command register (address 7) while idle makes status read 0x58 and interrupt reason read 0x01.
- R3: Bit 4 of the drive select register (address 6) must equal DEV_POS (default 1, so 0xB0 selects). While it does not, every read returns 0x0000 and command writes are ignored.
- R4: The packet is six 16-bit data-port (address 0) writes, and the opcode is bits 7:0 of the first write. The command runs only after the sixth write, and data-port writes outside the packet phase are ignored.
- R5: A mediaChange pulse raises intrq and leaves status at 0x50 until a command runs.
- R6: TEST UNIT READY (opcode 0x00) with a unit attention pending completes with status 0x41, error 0x60, interrupt reason 0x03 and intrq high.
- R7: TEST UNIT READY with no unit attention and no check condition completes with status 0x50, error 0x00, interrupt reason 0x03 and intrq high.
- R8: The check condition (status bit 0, error = sense key << 4) persists across further commands until a REQUEST SENSE finishes.
- R9: REQUEST SENSE (opcode 0x03) gives status 0x48, interrupt reason 0x02, byte count 0x0012 (address 4 = 0x12, address 5 = 0x00) and intrq high. Nine data reads return the sense bytes low byte first: byte 0 = 0x70, byte 2 = sense key, byte 12 = additional code, and all others zero.
- R10: After the ninth sense read, status reads 0x50, interrupt reason 0x03 and intrq is high. The check condition, the unit attention and the sense record are cleared, so a following TEST UNIT READY passes.
- R11: Reading status (address 7) clears intrq. Reading the alternate status (address 14) returns the same value and leaves intrq unchanged.
- R12: Any other opcode raises beReq with beOpcode and status 0x80 until beDone. beDone alone completes with status 0x50, reason 0x03 and intrq. beDone with beFail completes with status 0x41 and error beSenseKey << 4, and overwrites the sense record with beSenseKey/beAsc.
- R13: REQUEST SENSE with no error recorded returns 0x0070 followed by eight zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register index: 0-7 command block, 14 alternate status |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe (read side effects) |
| busWrData | input | 16 | Host write data |
| busRdData | output | 16 | Register read data (combinational) |
| intrq | output | 1 | Interrupt request |
| mediaChange | input | 1 | One-cycle media-change event |
| beReq | output | 1 | Backend command request |
| beOpcode | output | 8 | Opcode handed to backend |
| beDone | input | 1 | Backend completion pulse |
| beFail | input | 1 | Backend completion is an error |
| beSenseKey | input | 4 | Sense key reported on failure |
| beAsc | input | 8 | Additional sense code reported on failure |

## Verification
The hardest state to reach is a sense record overwritten while a unit attention is live. That means a media change and a backend failure racing each other, followed by a REQUEST SENSE that must report whichever event came last. The random phase issues backend opcodes with random failures and codes and injects media changes at random points between completion and the sense fetch. A reference model in the bench tracks which record must survive. Directed sequences cover the single-device select, partial packets, and the difference between the status and alternate-status reads.

// File: rtl/atapi_seq_pkg.sv
package atapi_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PKT  = 2'd1,
    PH_BUSY = 2'd2,
    PH_DIN  = 2'd3
  } phase_t;

  typedef struct packed {
    logic startPkt;
    logic enterDin;
    logic finish;
  } ctl_strobe_t;

  localparam logic [7:0] OP_PACKET = 8'hA0;
  localparam logic [7:0] OP_TUR    = 8'h00;
  localparam logic [7:0] OP_RSENSE = 8'h03;
  localparam logic [3:0] KEY_UATTN = 4'h6;
  localparam logic [7:0] ASC_MEDCH = 8'h28;
endpackage

// File: rtl/atapi_seq_dp.sv
module atapi_seq_dp
  import atapi_seq_pkg::*;
#(
  parameter int PKT_BYTES   = 12,
  parameter int SENSE_BYTES = 18,
  parameter int DEV_POS     = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  input  phase_t      phase,
  input  logic        errFlag,
  input  logic [3:0]  senseKey,
  input  logic [7:0]  asc,
  input  ctl_strobe_t strobe,
  output logic        cmdWr,
  output logic [7:0]  cmdVal,
  output logic        statusRd,
  output logic        pktLast,
  output logic        dinLast,
  output logic [7:0]  opcode
);
  localparam int PKT_WORDS   = PKT_BYTES / 2;
  localparam int SENSE_WORDS = SENSE_BYTES / 2;
  localparam int PCW = $clog2(PKT_WORDS);
  localparam int SCW = $clog2(SENSE_WORDS);
  localparam logic [PCW-1:0] PKT_LAST   = PCW'(PKT_WORDS - 1);
  localparam logic [SCW-1:0] SENSE_LAST = SCW'(SENSE_WORDS - 1);

  logic [7:0] featReg, reasonReg, secNumReg, cylLo, cylHi, devSel;
  logic [PCW-1:0] pktCnt;
  logic [SCW-1:0] dinCnt;
  logic sel, dataWr, dataRd;
  logic [7:0] statusVal;

  assign sel    = (devSel[4] == 1'(DEV_POS));
  assign cmdWr  = sel && busWrEn && (regAddr == 4'd7);
  assign cmdVal = busWrData[7:0];
  assign statusRd = sel && busRdEn && (regAddr == 4'd7);
  assign dataWr = sel && busWrEn && (regAddr == 4'd0) && (phase == PH_PKT);
  assign dataRd = sel && busRdEn && (regAddr == 4'd0) && (phase == PH_DIN);
  assign pktLast = dataWr && (pktCnt == PKT_LAST);
  assign dinLast = dataRd && (dinCnt == SENSE_LAST);

  function automatic logic [7:0] senseByte(input int idx, input logic [3:0] k,
                                           input logic [7:0] a);
    if (idx == 0)       return 8'h70;
    else if (idx == 2)  return {4'h0, k};
    else if (idx == 12) return a;
    else                return 8'h00;
  endfunction

  always_comb begin
    unique case (phase)
      PH_IDLE: statusVal = errFlag ? 8'h41 : 8'h50;
      PH_PKT:  statusVal = 8'h58;
      PH_BUSY: statusVal = 8'h80;
      default: statusVal = 8'h48;
    endcase
  end

  always_comb begin
    busRdData = 16'h0000;
    if (sel) begin
      unique case (regAddr)
        4'd0: if (phase == PH_DIN)
                busRdData = {senseByte(2*int'(dinCnt)+1, senseKey, asc),
                             senseByte(2*int'(dinCnt), senseKey, asc)};
        4'd1: busRdData = {8'h00, errFlag ? {senseKey, 4'h0} : 8'h00};
        4'd2: busRdData = {8'h00, reasonReg};
        4'd3: busRdData = {8'h00, secNumReg};
        4'd4: busRdData = {8'h00, cylLo};
        4'd5: busRdData = {8'h00, cylHi};
        4'd6: busRdData = {8'h00, devSel};
        4'd7, 4'd14: busRdData = {8'h00, statusVal};
        default: busRdData = 16'h0000;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      featReg <= '0; reasonReg <= '0; secNumReg <= '0;
      cylLo <= '0; cylHi <= '0; devSel <= '0;
      pktCnt <= '0; dinCnt <= '0; opcode <= '0;
    end else begin
      if (busWrEn && regAddr == 4'd6) devSel <= busWrData[7:0];
      if (sel && busWrEn && phase == PH_IDLE) begin
        unique case (regAddr)
          4'd1: featReg   <= busWrData[7:0];
          4'd2: reasonReg <= busWrData[7:0];
          4'd3: secNumReg <= busWrData[7:0];
          4'd4: cylLo     <= busWrData[7:0];
          4'd5: cylHi     <= busWrData[7:0];
          default: ;
        endcase
      end
      if (dataWr) begin
        pktCnt <= pktCnt + 1'b1;
        if (pktCnt == '0) opcode <= busWrData[7:0];
      end
      if (dataRd) dinCnt <= dinCnt + 1'b1;
      if (strobe.startPkt) begin
        pktCnt <= '0;
        reasonReg <= 8'h01;
      end
      if (strobe.enterDin) begin
        dinCnt <= '0;
        reasonReg <= 8'h02;
        cylLo <= SENSE_BYTES[7:0];
        cylHi <= 8'(SENSE_BYTES >> 8);
      end
      if (strobe.finish) reasonReg <= 8'h03;
    end
  end

  // R2
  pkt_reason_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PKT) |-> (reasonReg == 8'h01));
  // R9
  din_reason_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DIN) |-> (reasonReg == 8'h02 && cylLo == SENSE_BYTES[7:0]));
  // R3
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sel) |-> (busRdData == 16'h0000 && !statusRd));
endmodule

// File: rtl/atapi_seq_ctl.sv
module atapi_seq_ctl
  import atapi_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [7:0]  cmdVal,
  input  logic        statusRd,
  input  logic        pktLast,
  input  logic        dinLast,
  input  logic [7:0]  opcode,
  input  logic        mediaChange,
  input  logic        beDone,
  input  logic        beFail,
  input  logic [3:0]  beSenseKey,
  input  logic [7:0]  beAsc,
  output phase_t      phase,
  output logic        errFlag,
  output logic [3:0]  senseKey,
  output logic [7:0]  asc,
  output logic        irqPend,
  output ctl_strobe_t strobe
);
  logic uaPend;
  logic turDone;

  assign turDone = (phase == PH_PKT) && pktLast && (opcode == OP_TUR);

  always_comb begin
    strobe.startPkt = (phase == PH_IDLE) && cmdWr && (cmdVal == OP_PACKET);
    strobe.enterDin = (phase == PH_PKT) && pktLast && (opcode == OP_RSENSE);
    strobe.finish   = turDone || ((phase == PH_BUSY) && beDone)
                   || ((phase == PH_DIN) && dinLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE; errFlag <= 1'b0; uaPend <= 1'b0;
      senseKey <= '0; asc <= '0; irqPend <= 1'b0;
    end else begin
      if (statusRd) irqPend <= 1'b0;
      unique case (phase)
        PH_IDLE: if (strobe.startPkt) phase <= PH_PKT;
        PH_PKT: if (pktLast) begin
          if (opcode == OP_TUR) begin
            phase <= PH_IDLE;
            irqPend <= 1'b1;
            if (uaPend) errFlag <= 1'b1;
          end else if (opcode == OP_RSENSE) begin
            phase <= PH_DIN;
            irqPend <= 1'b1;
          end else begin
            phase <= PH_BUSY;
          end
        end
        PH_BUSY: if (beDone) begin
          phase <= PH_IDLE;
          irqPend <= 1'b1;
          if (beFail) begin
            errFlag <= 1'b1;
            uaPend <= 1'b0;
            senseKey <= beSenseKey;
            asc <= beAsc;
          end
        end
        default: if (dinLast) begin
          phase <= PH_IDLE;
          irqPend <= 1'b1;
          errFlag <= 1'b0;
          uaPend <= 1'b0;
          senseKey <= '0;
          asc <= '0;
        end
      endcase
      if (mediaChange) begin
        uaPend <= 1'b1;
        senseKey <= KEY_UATTN;
        asc <= ASC_MEDCH;
        irqPend <= 1'b1;
      end
    end
  end

  // R2
  pkt_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && cmdWr && cmdVal == OP_PACKET) |=> (phase == PH_PKT));
  // R5
  ua_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    mediaChange |=> (uaPend && irqPend && senseKey == KEY_UATTN));
  // R6
  tur_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (turDone && uaPend) |=> (errFlag && irqPend && phase == PH_IDLE));
  // R10
  sense_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DIN && dinLast && !mediaChange) |=> (!errFlag && !uaPend && irqPend));
  // R12
  be_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BUSY && beDone && beFail) |=> errFlag);
  // R11
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !mediaChange && !strobe.finish && !strobe.enterDin) |=> !irqPend);
endmodule

// File: rtl/atapi_pkt_seq.sv
module atapi_pkt_seq
  import atapi_seq_pkg::*;
#(
  parameter int PKT_BYTES   = 12,
  parameter int SENSE_BYTES = 18,
  parameter int DEV_POS     = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [15:0] busWrData,
  output logic [15:0] busRdData,
  output logic        intrq,
  input  logic        mediaChange,
  output logic        beReq,
  output logic [7:0]  beOpcode,
  input  logic        beDone,
  input  logic        beFail,
  input  logic [3:0]  beSenseKey,
  input  logic [7:0]  beAsc
);
  phase_t      phase;
  ctl_strobe_t strobe;
  logic        errFlag, irqPend, cmdWr, statusRd, pktLast, dinLast;
  logic [3:0]  senseKey;
  logic [7:0]  asc, cmdVal, opcode;

  atapi_seq_dp #(.PKT_BYTES(PKT_BYTES), .SENSE_BYTES(SENSE_BYTES), .DEV_POS(DEV_POS)) uDp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .phase(phase), .errFlag(errFlag),
    .senseKey(senseKey), .asc(asc), .strobe(strobe), .cmdWr(cmdWr), .cmdVal(cmdVal),
    .statusRd(statusRd), .pktLast(pktLast), .dinLast(dinLast), .opcode(opcode));

  atapi_seq_ctl uCtl (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdVal(cmdVal), .statusRd(statusRd),
    .pktLast(pktLast), .dinLast(dinLast), .opcode(opcode), .mediaChange(mediaChange),
    .beDone(beDone), .beFail(beFail), .beSenseKey(beSenseKey), .beAsc(beAsc),
    .phase(phase), .errFlag(errFlag), .senseKey(senseKey), .asc(asc),
    .irqPend(irqPend), .strobe(strobe));

  assign intrq    = irqPend;
  assign beReq    = (phase == PH_BUSY);
  assign beOpcode = opcode;

  // R12
  be_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beReq && !beDone) |=> (beReq && $stable(beOpcode)));
endmodule

// File: tb/sim_atapi_pkt_seq.sv
module sim_atapi_pkt_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic intrq, mediaChange = 1'b0, beReq, beDone = 1'b0, beFail = 1'b0;
  logic [7:0] beOpcode, beAsc = '0;
  logic [3:0] beSenseKey = '0;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  atapi_pkt_seq u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); regAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1 busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; busRdEn = 1'b1; #1 d = busRdData;
    @(posedge clk); #1 busRdEn = 1'b0;
  endtask

  task automatic pulseMc();
    @(negedge clk); mediaChange = 1'b1;
    @(negedge clk); mediaChange = 1'b0;
  endtask

  function automatic logic [15:0] expSense(input int w, input logic [3:0] k, input logic [7:0] a);
    logic [7:0] b [18];
    for (int i = 0; i < 18; i++) b[i] = 8'h00;
    b[0] = 8'h70; b[2] = {4'h0, k}; b[12] = a;
    return {b[2*w+1], b[2*w]};
  endfunction

  function automatic logic [15:0] expStatus(input bit err);
    return err ? 16'h0041 : 16'h0050;
  endfunction

  task automatic sendPkt(input logic [7:0] op, input int words);
    logic [15:0] v;
    wr(7, 16'h00A0);
    if (words == 6) begin
      rd(14, v); chk("R2 status", v, 16'h0058);
      rd(2, v);  chk("R2 reason", v, 16'h0001);
    end
    for (int i = 0; i < words; i++)
      wr(0, (i == 0) ? {8'($urandom), op} : 16'($urandom));
  endtask

  task automatic doSense(input string req, input logic [3:0] k, input logic [7:0] a);
    logic [15:0] v;
    sendPkt(8'h03, 6);
    rd(14, v); chk({req, " R9 status"}, v, 16'h0048);
    rd(2, v);  chk({req, " R9 reason"}, v, 16'h0002);
    rd(4, v);  chk({req, " R9 bcount lo"}, v, 16'h0012);
    rd(5, v);  chk({req, " R9 bcount hi"}, v, 16'h0000);
    chk({req, " R9 intrq"}, 16'(intrq), 16'h1);
    rd(7, v);
    for (int w = 0; w < 9; w++) begin
      rd(0, v); chk({req, " R9 sense word"}, v, expSense(w, k, a));
    end
    rd(14, v); chk({req, " R10 status"}, v, 16'h0050);
    rd(2, v);  chk({req, " R10 reason"}, v, 16'h0003);
    chk({req, " R10 intrq"}, 16'(intrq), 16'h1);
    rd(7, v);
  endtask

  task automatic tur(input string req, input bit expErr, input logic [3:0] k);
    logic [15:0] v;
    sendPkt(8'h00, 6);
    rd(14, v); chk({req, " status"}, v, expStatus(expErr));
    rd(1, v);  chk({req, " error"}, v, expErr ? {8'h00, k, 4'h0} : 16'h0000);
    rd(2, v);  chk({req, " reason"}, v, 16'h0003);
    chk({req, " intrq"}, 16'(intrq), 16'h1);
    rd(7, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bit errM, uaM;
    logic [3:0] keyM;
    logic [7:0] ascM;
    void'($urandom(32'h5EED_0A7A));
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    chk("R1 intrq", 16'(intrq), 16'h0);
    rd(7, v); chk("R3 unselected status", v, 16'h0000);
    wr(6, 16'h00B0);
    rd(14, v); chk("R1 status", v, 16'h0050);
    rd(2, v);  chk("R1 reason", v, 16'h0000);
    rd(1, v);  chk("R1 error", v, 16'h0000);

    // R3: deselect, command write ignored
    wr(6, 16'h00A0);
    wr(7, 16'h00A0);
    rd(2, v); chk("R3 unselected reason", v, 16'h0000);
    wr(6, 16'h00B0);
    rd(14, v); chk("R3 command ignored", v, 16'h0050);

    // R4: idle data writes ignored, partial packet does not run
    wr(0, 16'h0003); wr(0, 16'h0003);
    sendPkt(8'h00, 5);
    rd(14, v); chk("R4 partial packet", v, 16'h0058);
    chk("R4 no intrq", 16'(intrq), 16'h0);
    wr(0, 16'h0000);
    rd(14, v); chk("R4 sixth word completes", v, 16'h0050);
    rd(2, v);  chk("R7 reason", v, 16'h0003);

    // R11: alternate read keeps intrq, status read clears
    rd(14, v); chk("R11 alt keeps intrq", 16'(intrq), 16'h1);
    rd(7, v);  chk("R11 status read value", v, 16'h0050);
    chk("R11 status clears intrq", 16'(intrq), 16'h0);

    tur("R7", 1'b0, 4'h0);
    doSense("R13", 4'h0, 8'h00);

    pulseMc();
    chk("R5 intrq", 16'(intrq), 16'h1);
    rd(14, v); chk("R5 status", v, 16'h0050);
    rd(7, v);
    tur("R6", 1'b1, 4'h6);
    tur("R8", 1'b1, 4'h6);
    doSense("R9", 4'h6, 8'h28);
    tur("R10 pass", 1'b0, 4'h0);

    // R12 random backend commands with interleaved media changes
    errM = 0; uaM = 0; keyM = 0; ascM = 0;
    for (int it = 0; it < 40; it++) begin
      logic [7:0] op;
      bit f;
      logic [3:0] k;
      logic [7:0] a;
      int mcWhen;
      op = 8'($urandom);
      if (op == 8'h00 || op == 8'h03) op = 8'h43;
      f = 1'($urandom);
      k = 4'($urandom_range(1, 15));
      a = 8'($urandom);
      mcWhen = $urandom_range(0, 3);
      sendPkt(op, 6);
      rd(14, v); chk("R12 busy status", v, 16'h0080);
      chk("R12 beReq", 16'(beReq), 16'h1);
      chk("R12 beOpcode", 16'(beOpcode), {8'h00, op});
      repeat ($urandom_range(0, 5)) @(posedge clk);
      @(negedge clk); beDone = 1'b1; beFail = f; beSenseKey = k; beAsc = a;
      @(negedge clk); beDone = 1'b0; beFail = 1'b0;
      if (f) begin errM = 1; uaM = 0; keyM = k; ascM = a; end
      rd(14, v); chk("R12 completion status", v, expStatus(errM));
      rd(1, v);  chk("R12 error", v, errM ? {8'h00, keyM, 4'h0} : 16'h0000);
      rd(2, v);  chk("R12 reason", v, 16'h0003);
      chk("R12 intrq", 16'(intrq), 16'h1);
      rd(7, v);
      if (mcWhen == 0) begin
        pulseMc(); rd(7, v);
        uaM = 1; keyM = 4'h6; ascM = 8'h28;
      end
      if (mcWhen == 1) begin
        tur("R8 random", errM || uaM, keyM);
        if (uaM) errM = 1;
      end
      if (mcWhen != 3) begin
        doSense("R12 random", keyM, ascM);
        errM = 0; uaM = 0; keyM = 0; ascM = 0;
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule